// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the bytes of an incoming Ethernet frame as they stream past and makes the accept-or-drop decision from the destination address. The destination is the first six bytes of the frame. It recognises three kinds of destination. The first is the all-ones broadcast address. The second is a group address, which is checked against a 64-bin hash table. The third is a single-station address, which is compared with a programmed station address. Frames that miss are dropped. The exception is promiscuous mode, which passes them on but marks them with a miss flag so the receive descriptor status can record it.

The decision comes out as a single-cycle done strobe with accept and miss qualifiers. It appears one cycle after the sixth byte, or one cycle after the closing byte of a frame too short to carry a full destination. After the decision, the block ignores the rest of the frame and re-arms on the byte that follows the closing byte. The configuration inputs are static register contents and are read in the done cycle.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, done, accept and miss are low, and the first valid byte is taken as byte 0 of a destination.
- R2: The cycle after the sixth valid byte of a frame, done is high for exactly one cycle. Later bytes of that frame raise no further done, and cycles with in_valid low are not counted.
- R3: If in_last arrives on one of the first five valid bytes, done rises the next cycle with miss high. The frame is a miss whatever those bytes hold.
- R4: An all-ones destination is broadcast. It hits when cfg_bcast_reject is 0 and misses when it is 1, even if it also qualifies for the hash path.
- R5: A non-broadcast destination whose byte 0 has bit 0 set takes its hit from the hash table. The index is bits 31:26 of a CRC-32 over the six bytes. The CRC runs byte 0 first and least significant bit first, uses the reflected polynomial 0xEDB88320, starts from all ones and is not inverted at the end. Index bit 5 selects hash_hi (1) or hash_lo (0), and index bits 4:0 pick the bit within that word.
- R6: With cfg_hash_all at 1, non-broadcast destinations with byte 0 bit 0 clear also take their hit from the hash table, and the station address is not consulted.
- R7: Otherwise the frame hits only if all six bytes equal the station address. Byte 0 is station_hi[15:8] and byte 1 is station_hi[7:0]. Bytes 2, 3, 4 and 5 are station_lo[31:24], [23:16], [15:8] and [7:0].
- R8: In the done cycle, miss is the inverse of the hit. Accept equals the hit when cfg_promisc is 0 and is 1 when cfg_promisc is 1.
- R9: Accept and miss are low in every cycle where done is low.
- R10: The valid byte after an in_last byte is byte 0 of the next frame. This holds when frames are back to back, and also when in_last falls on the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte closes the frame |
| cfg_bcast_reject | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Route single-station addresses through the hash table |
| cfg_promisc | input | 1 | Accept missed frames as well |
| station_hi | input | 16 | Station address bytes 0 and 1 |
| station_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash bins 0 to 31 |
| hash_hi | input | 32 | Hash bins 32 to 63 |
| done | output | 1 | Decision strobe |
| accept | output | 1 | Frame is to be kept |
| miss | output | 1 | Destination did not hit |

## Verification
The bench builds the block with its default CRC polynomial and seed. With those defaults, the bench's own bitwise CRC model produces the same hash index as the design, so any of the 64 bins can be targeted by one chosen address. Each hash case sets exactly the computed bin, or every bin except it. This catches word-select and bit-select faults as well as CRC faults. The sixth-byte trigger, the five-byte short-frame boundary and the re-arm after in_last are driven with and without idle gaps and with frames back to back.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int unsigned OCTET_W    = 8;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = OCTET_W * ADDR_BYTES;
  localparam int unsigned CNT_W      = $clog2(ADDR_BYTES);
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_WORD  = 32;

  typedef enum logic {ST_COLLECT = 1'b0, ST_SKIP = 1'b1} cap_state_e;

  // One octet of a reflected (LSB-first) CRC.
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c_in,
                                                  input logic [OCTET_W-1:0] d,
                                                  input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int b = 0; b < OCTET_W; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ poly;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture
  import rxaf_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OCTET_W-1:0]   in_data,
  input  logic                 in_last,
  output logic [ADDR_W-1:0]    dst_o,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 fire_o,
  output logic                 short_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  cap_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  dst_q;
  logic [CRC_W-1:0]   crc_q, crc_d;
  logic               fire_q, short_q;
  logic               take, full, early;

  assign take  = in_valid && (state_q == ST_COLLECT);
  assign full  = take && (cnt_q == LAST_IDX);
  assign early = take && in_last && !full;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (take) begin
      cnt_d = (full || early) ? '0 : cnt_q + 1'b1;
      if (full && !in_last) state_d = ST_SKIP;
    end else if (in_valid && in_last) begin
      state_d = ST_COLLECT;
    end
    crc_d = crc_octet((cnt_q == '0) ? CRC_SEED : crc_q, in_data, CRC_POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fire_q  <= full || early;
      short_q <= early;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (take) crc_q <= crc_d;
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dst_q[i*OCTET_W +: OCTET_W] <= '0;
      else if (take && (cnt_q == CNT_W'(i))) dst_q[i*OCTET_W +: OCTET_W] <= in_data;
    end
  end

  assign dst_o   = dst_q;
  assign crc_o   = crc_q;
  assign fire_o  = fire_q;
  assign short_o = short_q;
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
  import rxaf_pkg::*;
(
  input  logic [ADDR_W-1:0]    dst_i,
  input  logic [CRC_W-1:0]     crc_i,
  input  logic                 short_i,
  input  logic                 bcast_reject_i,
  input  logic                 hash_all_i,
  input  logic [15:0]          station_hi_i,
  input  logic [31:0]          station_lo_i,
  input  logic [HASH_WORD-1:0] hash_lo_i,
  input  logic [HASH_WORD-1:0] hash_hi_i,
  output logic                 hit_o
);
  logic [ADDR_W-1:0]     station;
  logic [HASH_IDX_W-1:0] idx;
  logic                  is_bcast, use_hash, hash_hit, stn_hit;

  // byte k of the destination sits at dst_i[8k +: 8]
  assign station = {station_lo_i[7:0],  station_lo_i[15:8],
                    station_lo_i[23:16], station_lo_i[31:24],
                    station_hi_i[7:0],  station_hi_i[15:8]};

  assign idx      = crc_i[CRC_W-1 -: HASH_IDX_W];
  assign hash_hit = idx[HASH_IDX_W-1] ? hash_hi_i[idx[HASH_IDX_W-2:0]]
                                      : hash_lo_i[idx[HASH_IDX_W-2:0]];
  assign is_bcast = &dst_i;
  assign use_hash = dst_i[0] || hash_all_i;
  assign stn_hit  = (dst_i == station);

  always_comb begin
    if (short_i)       hit_o = 1'b0;
    else if (is_bcast) hit_o = !bcast_reject_i;
    else if (use_hash) hit_o = hash_hit;
    else               hit_o = stn_hit;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter logic [31:0] CRC_POLY = 32'hEDB8_8320,
  parameter logic [31:0] CRC_SEED = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        cfg_bcast_reject,
  input  logic        cfg_hash_all,
  input  logic        cfg_promisc,
  input  logic [15:0] station_hi,
  input  logic [31:0] station_lo,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  output logic        done,
  output logic        accept,
  output logic        miss
);
  logic [ADDR_W-1:0] dst;
  logic [CRC_W-1:0]  crc;
  logic              fire, short_frm, hit;

  rxaf_capture #(.CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .dst_o(dst), .crc_o(crc), .fire_o(fire), .short_o(short_frm)
  );

  rxaf_match u_match (
    .dst_i(dst), .crc_i(crc), .short_i(short_frm),
    .bcast_reject_i(cfg_bcast_reject), .hash_all_i(cfg_hash_all),
    .station_hi_i(station_hi), .station_lo_i(station_lo),
    .hash_lo_i(hash_lo), .hash_hi_i(hash_hi), .hit_o(hit)
  );

  assign done   = fire;
  assign accept = fire && (hit || cfg_promisc);
  assign miss   = fire && !hit;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rxaf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        in_last,
  input logic        cfg_bcast_reject,
  input logic        cfg_hash_all,
  input logic        cfg_promisc,
  input logic [15:0] station_hi,
  input logic [31:0] station_lo,
  input logic [31:0] hash_lo,
  input logic [31:0] hash_hi,
  input logic        done,
  input logic        accept,
  input logic        miss
);
  // bytes seen in the current frame, held at ADDR_BYTES once reached
  logic [CNT_W:0] seen_q;
  logic           trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid) begin
      if (in_last) seen_q <= '0;
      else if (seen_q < (CNT_W+1)'(ADDR_BYTES)) seen_q <= seen_q + 1'b1;
    end
  end

  assign trig = in_valid && ((seen_q == (CNT_W+1)'(ADDR_BYTES-1)) ||
                             (in_last && seen_q < (CNT_W+1)'(ADDR_BYTES-1)));

  assert_sixth_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && seen_q == (CNT_W+1)'(ADDR_BYTES-1) |=> done);
  assert_no_extra_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> !done);
  assert_short_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last && seen_q < (CNT_W+1)'(ADDR_BYTES-1) |=> done && miss);
  assert_promisc_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && cfg_promisc |-> accept);
  assert_accept_xor_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfg_promisc |-> accept != miss);
  assert_flags_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !accept && !miss);
endmodule

bind rx_addr_filter rx_addr_filter_chk chk_i (.*);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [7:0]  in_data;
  logic        cfg_bcast_reject, cfg_hash_all, cfg_promisc;
  logic [15:0] station_hi;
  logic [31:0] station_lo, hash_lo, hash_hi;
  logic        done, accept, miss;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] fr [16];

  always #2 clk = ~clk;

  rx_addr_filter dut_i (.*);

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] ref_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[k][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c;
  endfunction

  function automatic int ref_idx();
    logic [31:0] c = ref_crc();
    return int'(c[31:26]);
  endfunction

  function automatic logic ref_hit(input int len);
    logic [63:0] tbl = {hash_hi, hash_lo};
    logic bc = 1'b1;
    if (len < 6) return 1'b0;
    for (int k = 0; k < 6; k++) bc &= (fr[k] == 8'hFF);
    if (bc) return !cfg_bcast_reject;
    if (fr[0][0] || cfg_hash_all) return tbl[ref_idx()];
    return fr[0] == station_hi[15:8] && fr[1] == station_hi[7:0] &&
           fr[2] == station_lo[31:24] && fr[3] == station_lo[23:16] &&
           fr[4] == station_lo[15:8] && fr[5] == station_lo[7:0];
  endfunction

  task automatic set_dst(input logic [47:0] a);
    for (int k = 0; k < 6; k++) fr[k] = a[47-8*k -: 8];
    for (int k = 6; k < 16; k++) fr[k] = 8'(k * 17);
  endtask

  // Drive one frame; gap idle cycles after each byte; check done every cycle.
  task automatic send_frame(input string req, input int len, input int gap);
    logic eh = ref_hit(len);
    for (int i = 0; i < len; i++) begin
      bit trig = (i == 5) || (i == len - 1 && len < 6);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == len - 1);
      @(posedge clk); #1;
      in_valid = 1'b0; in_last = 1'b0;
      check(req, $sformatf("done after byte %0d", i), done, trig);
      if (trig) begin
        check(req, "accept", accept, eh | cfg_promisc);
        check(req, "miss", miss, !eh);
      end else begin
        check("R9", "accept low without done", accept, 1'b0);
        check("R9", "miss low without done", miss, 1'b0);
      end
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        check("R2", "done during idle gap", done, 1'b0);
      end
    end
  endtask

  task automatic t_reset();
    check("R1", "done after reset", done, 1'b0);
    check("R1", "accept after reset", accept, 1'b0);
    check("R1", "miss after reset", miss, 1'b0);
  endtask

  task automatic t_unicast();
    station_hi = 16'h0A1B; station_lo = 32'h2C3D4E5F;
    set_dst(48'h0A1B_2C3D_4E5F); send_frame("R7 station match", 8, 0);
    check("R7", "match hit", accept, 1'b0);  // done already past: flags low
    set_dst(48'h0B1B_2C3D_4E5F); send_frame("R7 byte0 differs", 8, 0);
    set_dst(48'h0A1B_2C3D_4E5E); send_frame("R7 byte5 differs", 8, 0);
    set_dst(48'h0A1B_3D2C_4E5F); send_frame("R7 bytes swapped", 6, 0);
  endtask

  task automatic t_bcast();
    set_dst(48'hFFFF_FFFF_FFFF);
    cfg_bcast_reject = 1'b0; send_frame("R4 broadcast kept", 7, 0);
    cfg_bcast_reject = 1'b1; send_frame("R4 broadcast rejected", 7, 0);
    cfg_bcast_reject = 1'b0; cfg_hash_all = 1'b1; hash_lo = '0; hash_hi = '0;
    send_frame("R4 broadcast beats hash", 7, 0);
    cfg_hash_all = 1'b0;
  endtask

  task automatic set_bin(input int idx, input bit only);
    logic [63:0] t = only ? 64'd0 : ~64'd0;
    t[idx] = only;
    hash_lo = t[31:0]; hash_hi = t[63:32];
  endtask

  task automatic t_hash();
    set_dst(48'h0100_5E00_0001); set_bin(ref_idx(), 1);
    send_frame("R5 group bin set", 9, 0);
    set_bin(ref_idx(), 0); send_frame("R5 group bin clear", 9, 0);
    set_dst(48'h3333_0000_00FB); set_bin(ref_idx(), 1);
    send_frame("R5 second group bin", 6, 0);
    set_bin(ref_idx() ^ 32, 1); send_frame("R5 wrong word", 6, 0);
    // hash-all: station-matching address but bin cleared, then mismatch with bin set
    station_hi = 16'h0A1B; station_lo = 32'h2C3D4E5F; cfg_hash_all = 1'b1;
    set_dst(48'h0A1B_2C3D_4E5F); set_bin(ref_idx(), 0);
    send_frame("R6 hash-all ignores station", 7, 0);
    set_dst(48'h5A1B_2C3D_4E50); set_bin(ref_idx(), 1);
    send_frame("R6 hash-all bin hit", 7, 0);
    cfg_hash_all = 1'b0;
  endtask

  task automatic t_promisc();
    cfg_promisc = 1'b1;
    set_dst(48'h0011_2233_4455); send_frame("R8 promisc miss kept", 8, 0);
    set_dst(48'h0A1B_2C3D_4E5F); send_frame("R8 promisc hit", 8, 0);
    set_dst(48'h0A1B_2C3D_4E5F); send_frame("R3 short promisc", 3, 0);
    cfg_promisc = 1'b0;
  endtask

  task automatic t_short();
    set_dst(48'h0A1B_2C3D_4E5F);
    send_frame("R3 short 5 bytes", 5, 0);
    send_frame("R3 short 1 byte", 1, 0);
    send_frame("R3 short with gaps", 4, 2);
  endtask

  task automatic t_sequence();
    set_dst(48'h0A1B_2C3D_4E5F);
    send_frame("R2 gaps between bytes", 7, 3);
    send_frame("R10 back to back long", 14, 0);
    send_frame("R10 exact six", 6, 0);
    send_frame("R10 after exact six", 6, 0);
    @(posedge clk); #1;
    check("R9", "idle done", done, 1'b0);
    check("R9", "idle accept", accept, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    cfg_bcast_reject = 1'b0; cfg_hash_all = 1'b0; cfg_promisc = 1'b0;
    station_hi = '0; station_lo = '0; hash_lo = '0; hash_hi = '0;
    for (int k = 0; k < 16; k++) fr[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_unicast();
    t_bcast();
    t_hash();
    t_promisc();
    t_short();
    t_sequence();
    finish_run();
  end
endmodule